// File: doc/BRIEF.md
# Asynchronous serial receiver with break detection

This block receives a single channel of asynchronous serial data. A 16x sample-enable strobe paces the line. The block recovers characters of 5 to 8 data bits. A parity bit may follow the data, and it can be checked for odd or even sense or against a fixed value. Each finished character goes into a 16-entry holding buffer together with its own status bits: parity error, framing error, break and address. The consumer reads entries in arrival order through a show-ahead port.

A low glitch that has gone high again by the middle of the start bit is rejected. A line held low is reported once as a break, with a pulse when the break begins and another when the line returns high. This also works when the line drops in the middle of a character.

For multi-drop buses, the parity slot can carry an address/data flag. A sleeping receiver then discards data characters until an address character arrives. A watchdog pulses when characters sit unread in the buffer and no new character has arrived for a programmable number of sample ticks.

Top module: `serin_rx`

## Requirements
- R1: `cfg_len` selects 5 + `cfg_len` data bits (0 gives 5, 3 gives 8). The bits arrive least significant first and are stored in the low bits of `rd_data`; the unused upper bits read 0.
- R2: `cfg_par` selects the parity bit that follows the data: 0 none, 1 even, 2 odd, 3 fixed. In fixed mode the bit must equal `cfg_par_fix`. A mismatch sets `rd_perr` for that entry.
- R3: A stop bit sampled low on a character that is not a break sets `rd_frm` with `rd_brk` clear, and keeps the received data.
- R4: A low level that is high again at the start-bit mid sample (tick 8 of 16) is discarded. No entry is written and the receiver returns to idle.
- R5: A frame whose data, parity slot and stop bit are all 0 is a break. It writes exactly one entry (data 0, `rd_brk`=1, `rd_frm`=1, `rd_perr`=0) and pulses `brk_start` once. It writes nothing more until the line is high again, and then pulses `brk_end` once.
- R6: A break that starts inside a character first yields that character with `rd_frm`=1, then one break entry as in R5.
- R7: The buffer holds 16 entries in arrival order. `rd_valid` shows that the head entry is present, and `rd_en` removes it.
- R8: A character that completes while the buffer is full is dropped and pulses `ovr_evt`. The stored entries are unchanged.
- R9: With `cfg_mdrop`=1 a ninth bit always follows the data. That bit is copied to `rd_addr` (1 = address) and no parity error is raised.
- R10: A `sleep_req` pulse while `cfg_mdrop`=1 puts the receiver to sleep. Data characters are then discarded without `ovr_evt`. The next address character is stored and wakes the receiver.
- R11: While the buffer is non-empty and no character is stored for `wd_limit` ticks, `wd_evt` pulses once. A new stored character re-arms it. A `wd_limit` of 0 disables it.
- R12: After reset the buffer is empty, the receiver is awake and idle, and all event outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Sample enable, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 fixed |
| cfg_par_fix | input | 1 | Expected parity bit in fixed mode |
| cfg_mdrop | input | 1 | Parity slot carries the address flag |
| sleep_req | input | 1 | Pulse: sleep until an address character |
| wd_limit | input | WD_W | Watchdog timeout in ticks, 0 disables |
| rd_en | input | 1 | Remove the head entry |
| rd_valid | output | 1 | Head entry present |
| rd_data | output | 8 | Head character |
| rd_perr | output | 1 | Head parity error |
| rd_frm | output | 1 | Head framing error |
| rd_brk | output | 1 | Head is a break entry |
| rd_addr | output | 1 | Head is an address character |
| ovr_evt | output | 1 | Pulse: character dropped, buffer full |
| brk_start | output | 1 | Pulse: break began |
| brk_end | output | 1 | Pulse: line high after break |
| wd_evt | output | 1 | Pulse: watchdog timeout |

## Verification
The line passes through two synchronizer flops, and each bit is taken on the eighth sample tick into its cell. An entry and its `brk_start` pulse therefore appear one clock after the mid sample of the stop bit, roughly half a bit time plus three clocks after the stop bit begins. `brk_end` follows one tick plus the synchronizer delay after the line rises, and `wd_evt` comes `wd_limit` ticks after the last stored character. The bench never samples inside these windows: it idles the line for two full bit times after every frame before reading the buffer. Event pulses are counted on every falling clock edge, so the checks compare totals rather than the exact cycle of each pulse.

// File: rtl/serin_pkg.sv
package serin_pkg;

    localparam int OSR = 16;
    localparam int MID = 7;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_ODD   = 2'd2,
        PAR_FIXED = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRK
    } rx_state_e;

    typedef struct packed {
        logic       addr;
        logic       brk;
        logic       frm;
        logic       perr;
        logic [7:0] data;
    } rx_entry_t;

    function automatic logic [2:0] last_bit_index(input logic [1:0] len);
        return 3'd4 + {1'b0, len};
    endfunction

    function automatic logic parity_fault(input par_mode_e mode, input logic [7:0] d,
                                          input logic p, input logic fix);
        logic r;
        unique case (mode)
            PAR_EVEN:  r = ^{d, p};
            PAR_ODD:   r = ~^{d, p};
            PAR_FIXED: r = p ^ fix;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/serin_sampler.sv
module serin_sampler
    import serin_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rxd,
    input  logic [1:0] cfg_len,
    input  par_mode_e cfg_par,
    input  logic      cfg_fix,
    input  logic      cfg_mdrop,
    output logic      ld_valid,
    output rx_entry_t ld_entry,
    output logic      brk_start,
    output logic      brk_end
);

    rx_state_e  state;
    logic [3:0] sub;
    logic [2:0] bitidx;
    logic [7:0] shreg;
    logic       pbit;
    logic       has_par;
    logic [2:0] last_idx;
    logic       perr_c;
    logic       is_brk;

    assign has_par  = (cfg_par != PAR_NONE) || cfg_mdrop;
    assign last_idx = last_bit_index(cfg_len);
    assign perr_c   = cfg_mdrop ? 1'b0 : parity_fault(cfg_par, shreg, pbit, cfg_fix);
    assign is_brk   = !rxd && (shreg == 8'd0) && !(has_par && pbit);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            sub       <= '0;
            bitidx    <= '0;
            shreg     <= '0;
            pbit      <= 1'b0;
            ld_valid  <= 1'b0;
            ld_entry  <= '0;
            brk_start <= 1'b0;
            brk_end   <= 1'b0;
        end else begin
            ld_valid  <= 1'b0;
            brk_start <= 1'b0;
            brk_end   <= 1'b0;
            if (tick) begin
                unique case (state)
                    ST_IDLE: begin
                        if (!rxd) begin
                            state <= ST_START;
                            sub   <= 4'd1;
                        end
                    end
                    ST_START: begin
                        if (sub == 4'(MID)) begin
                            sub <= '0;
                            if (rxd) begin
                                state <= ST_IDLE;
                            end else begin
                                state  <= ST_DATA;
                                bitidx <= '0;
                                shreg  <= '0;
                                pbit   <= 1'b0;
                            end
                        end else begin
                            sub <= sub + 4'd1;
                        end
                    end
                    ST_DATA: begin
                        if (sub == 4'(OSR - 1)) begin
                            sub           <= '0;
                            shreg[bitidx] <= rxd;
                            if (bitidx == last_idx) begin
                                state <= has_par ? ST_PAR : ST_STOP;
                            end else begin
                                bitidx <= bitidx + 3'd1;
                            end
                        end else begin
                            sub <= sub + 4'd1;
                        end
                    end
                    ST_PAR: begin
                        if (sub == 4'(OSR - 1)) begin
                            sub   <= '0;
                            pbit  <= rxd;
                            state <= ST_STOP;
                        end else begin
                            sub <= sub + 4'd1;
                        end
                    end
                    ST_STOP: begin
                        if (sub == 4'(OSR - 1)) begin
                            sub      <= '0;
                            ld_valid <= 1'b1;
                            if (is_brk) begin
                                ld_entry  <= '{addr: 1'b0, brk: 1'b1, frm: 1'b1,
                                               perr: 1'b0, data: 8'd0};
                                brk_start <= 1'b1;
                                state     <= ST_BRK;
                            end else begin
                                ld_entry <= '{addr: cfg_mdrop & pbit, brk: 1'b0,
                                              frm: !rxd, perr: perr_c, data: shreg};
                                state    <= ST_IDLE;
                            end
                        end else begin
                            sub <= sub + 4'd1;
                        end
                    end
                    ST_BRK: begin
                        if (rxd) begin
                            brk_end <= 1'b1;
                            state   <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R4: a start that is high again at mid sample returns to idle with no load
    assert_false_start_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && state == ST_START && sub == 4'(MID) && rxd) |=> (state == ST_IDLE && !ld_valid));

    // R5: end of break only ever follows the break-wait state
    assert_brk_end_R5: assert property (@(posedge clk) disable iff (rst)
        brk_end |-> $past(state) == ST_BRK);

endmodule

// File: rtl/serin_fifo.sv
module serin_fifo
    import serin_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  rx_entry_t din,
    input  logic      pop,
    output rx_entry_t dout,
    output logic      empty,
    output logic      full,
    output logic      drop
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rx_entry_t      mem [DEPTH];
    logic [AW-1:0]  wp;
    logic [AW-1:0]  rp;
    logic [CW-1:0]  cnt;
    logic           do_wr;
    logic           do_rd;

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign do_wr = push && !full;
    assign do_rd = pop && !empty;
    assign dout  = mem[rp];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp   <= '0;
            rp   <= '0;
            cnt  <= '0;
            drop <= 1'b0;
        end else begin
            drop <= push && full;
            if (do_wr) wp <= bump(wp);
            if (do_rd) rp <= bump(rp);
            cnt <= cnt + CW'(do_wr) - CW'(do_rd);
        end
    end

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    assert_push_grows_R7: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !pop) |=> cnt == $past(cnt) + CW'(1));

    assert_drop_keeps_full_R8: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> full);

endmodule

// File: rtl/serin_wdog.sv
module serin_wdog #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         busy,
    input  logic         kick,
    input  logic [W-1:0] limit,
    output logic         fire
);

    localparam int W1 = W + 1;

    logic [W-1:0] cnt;
    logic         armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            armed <= 1'b1;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (kick || !busy) begin
                cnt   <= '0;
                armed <= 1'b1;
            end else if (tick && armed && limit != '0) begin
                if (W1'(cnt) + W1'(1) == W1'(limit)) begin
                    fire  <= 1'b1;
                    armed <= 1'b0;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + W'(1);
                end
            end
        end
    end

    assert_single_fire_R11: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

    assert_fire_busy_R11: assert property (@(posedge clk) disable iff (rst)
        fire |-> $past(busy));

endmodule

// File: rtl/serin_rx.sv
module serin_rx
    import serin_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WD_W  = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick16,
    input  logic            rxd,
    input  logic [1:0]      cfg_len,
    input  logic [1:0]      cfg_par,
    input  logic            cfg_par_fix,
    input  logic            cfg_mdrop,
    input  logic            sleep_req,
    input  logic [WD_W-1:0] wd_limit,
    input  logic            rd_en,
    output logic            rd_valid,
    output logic [7:0]      rd_data,
    output logic            rd_perr,
    output logic            rd_frm,
    output logic            rd_brk,
    output logic            rd_addr,
    output logic            ovr_evt,
    output logic            brk_start,
    output logic            brk_end,
    output logic            wd_evt
);

    logic [1:0] sync_q;
    logic       rxd_s;
    logic       ld_valid;
    rx_entry_t  ld_entry;
    rx_entry_t  head;
    logic       asleep;
    logic       push;
    logic       f_empty;
    logic       f_full;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rxd};
    end
    assign rxd_s = sync_q[1];

    serin_sampler u_samp (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick16),
        .rxd       (rxd_s),
        .cfg_len   (cfg_len),
        .cfg_par   (par_mode_e'(cfg_par)),
        .cfg_fix   (cfg_par_fix),
        .cfg_mdrop (cfg_mdrop),
        .ld_valid  (ld_valid),
        .ld_entry  (ld_entry),
        .brk_start (brk_start),
        .brk_end   (brk_end)
    );

    always_ff @(posedge clk) begin
        if (rst || !cfg_mdrop)                asleep <= 1'b0;
        else if (sleep_req)                   asleep <= 1'b1;
        else if (ld_valid && ld_entry.addr)   asleep <= 1'b0;
    end

    assign push = ld_valid && (!asleep || ld_entry.addr);

    serin_fifo #(.DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (ld_entry),
        .pop   (rd_en),
        .dout  (head),
        .empty (f_empty),
        .full  (f_full),
        .drop  (ovr_evt)
    );

    serin_wdog #(.W(WD_W)) u_wd (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick16),
        .busy  (!f_empty),
        .kick  (push),
        .limit (wd_limit),
        .fire  (wd_evt)
    );

    assign rd_valid = !f_empty;
    assign rd_data  = head.data;
    assign rd_perr  = head.perr;
    assign rd_frm   = head.frm;
    assign rd_brk   = head.brk;
    assign rd_addr  = head.addr;

    assert_rdvalid_after_push_R7: assert property (@(posedge clk) disable iff (rst)
        push |=> rd_valid);

    assert_ovr_when_full_R8: assert property (@(posedge clk) disable iff (rst)
        ovr_evt |-> $past(f_full));

endmodule

// File: tb/sim_serin_rx.sv
module sim_serin_rx;
    import serin_pkg::*;

    localparam int BITC = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick16 = 1'b0;
    logic        rxd = 1'b1;
    logic [1:0]  cfg_len = 2'd3;
    logic [1:0]  cfg_par = 2'd0;
    logic        cfg_par_fix = 1'b0;
    logic        cfg_mdrop = 1'b0;
    logic        sleep_req = 1'b0;
    logic [11:0] wd_limit = '0;
    logic        rd_en = 1'b0;
    logic        rd_valid, rd_perr, rd_frm, rd_brk, rd_addr;
    logic [7:0]  rd_data;
    logic        ovr_evt, brk_start, brk_end, wd_evt;

    int vectors = 0;
    int miscmp  = 0;
    int n_ovr = 0, n_bs = 0, n_be = 0, n_wd = 0;

    always #2 clk = ~clk;

    serin_rx u0 (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_par_fix(cfg_par_fix),
        .cfg_mdrop(cfg_mdrop), .sleep_req(sleep_req), .wd_limit(wd_limit),
        .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .rd_perr(rd_perr),
        .rd_frm(rd_frm), .rd_brk(rd_brk), .rd_addr(rd_addr), .ovr_evt(ovr_evt),
        .brk_start(brk_start), .brk_end(brk_end), .wd_evt(wd_evt)
    );

    always @(negedge clk) begin
        tick16 <= ~tick16;
        if (!rst) begin
            if (ovr_evt)   n_ovr++;
            if (brk_start) n_bs++;
            if (brk_end)   n_be++;
            if (wd_evt)    n_wd++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscmp++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input int cyc);
        rxd = b;
        repeat (cyc) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input int nb, input bit hp,
                              input logic p, input logic stp, input int stop_cyc);
        send_bit(1'b0, BITC);
        for (int i = 0; i < nb; i++) send_bit(d[i], BITC);
        if (hp) send_bit(p, BITC);
        send_bit(stp, stop_cyc);
        send_bit(1'b1, 2 * BITC);
    endtask

    task automatic take(input string req, input logic [7:0] d, input logic pe,
                        input logic fe, input logic bk, input logic ad);
        check({req, " valid"}, int'(rd_valid), 1);
        check({req, " data"},  int'(rd_data), int'(d));
        check({req, " perr"},  int'(rd_perr), int'(pe));
        check({req, " frm"},   int'(rd_frm), int'(fe));
        check({req, " brk"},   int'(rd_brk), int'(bk));
        check({req, " addr"},  int'(rd_addr), int'(ad));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(negedge clk);
        miscmp++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        repeat (6) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R12: reset state
        check("R12 rd_valid", int'(rd_valid), 0);
        check("R12 events", int'({ovr_evt, brk_start, brk_end, wd_evt}), 0);

        // R1 R2: sweep of lengths, parity modes and data, with injected parity faults
        for (int l = 0; l < 4; l++) begin
            for (int pm = 0; pm < 4; pm++) begin
                for (int i = 0; i < 6; i++) begin
                    int nb;
                    logic [7:0] d, dm;
                    logic fx, pgood, flip;
                    nb  = 5 + l;
                    d   = 8'(i * 37 + 11 + l * 5 + pm * 3);
                    dm  = d & 8'((1 << nb) - 1);
                    fx  = i[0];
                    flip = (i % 3 == 2);
                    case (pm)
                        1: pgood = ^dm;
                        2: pgood = ~^dm;
                        3: pgood = fx;
                        default: pgood = 1'b0;
                    endcase
                    cfg_len = 2'(l);
                    cfg_par = 2'(pm);
                    cfg_par_fix = fx;
                    send_frame(d, nb, pm != 0, pgood ^ flip, 1'b1, BITC);
                    take($sformatf("R1 R2 len=%0d par=%0d i=%0d", nb, pm, i),
                         dm, (pm != 0) && flip, 1'b0, 1'b0, 1'b0);
                end
            end
        end
        check("R11 disabled when limit 0", n_wd, 0);
        check("R5 no break in sweep", n_bs, 0);

        cfg_len = 2'd3; cfg_par = 2'd0;

        // R3: low stop bit on non-zero data
        send_frame(8'h55, 8, 1'b0, 1'b0, 1'b0, 24);
        take("R3 framing", 8'h55, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R3 nothing extra", int'(rd_valid), 0);

        // R4: short low glitch is rejected
        send_bit(1'b0, 8);
        send_bit(1'b1, 3 * BITC);
        check("R4 glitch ignored", int'(rd_valid), 0);
        send_frame(8'hA5, 8, 1'b0, 1'b0, 1'b1, BITC);
        take("R4 next frame intact", 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0);

        // R5: full break
        send_bit(1'b0, 30 * BITC);
        check("R5 brk_start once", n_bs, 1);
        check("R5 no brk_end while low", n_be, 0);
        send_bit(1'b1, 2 * BITC);
        check("R5 brk_end once", n_be, 1);
        take("R5 break entry", 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R5 single entry", int'(rd_valid), 0);

        // R6: break that begins inside a character
        send_bit(1'b0, BITC);
        send_bit(1'b1, BITC);
        send_bit(1'b1, BITC);
        send_bit(1'b0, 30 * BITC);
        send_bit(1'b1, 2 * BITC);
        take("R6 truncated char", 8'h03, 1'b0, 1'b1, 1'b0, 1'b0);
        take("R6 break entry", 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R6 brk_start", n_bs, 2);
        check("R6 brk_end", n_be, 2);

        // R7 R8: fill past capacity
        for (int k = 0; k < 17; k++)
            send_frame(8'(k * 13 + 1), 8, 1'b0, 1'b0, 1'b1, BITC);
        check("R8 overrun pulse", n_ovr, 1);
        for (int k = 0; k < 16; k++)
            take($sformatf("R7 R8 order %0d", k), 8'(k * 13 + 1), 1'b0, 1'b0, 1'b0, 1'b0);
        check("R7 empty after drain", int'(rd_valid), 0);

        // R9 R10: multi-drop with sleep
        cfg_mdrop = 1'b1;
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        send_frame(8'h11, 8, 1'b1, 1'b0, 1'b1, BITC);
        check("R10 data dropped asleep", int'(rd_valid), 0);
        check("R10 no overrun", n_ovr, 1);
        send_frame(8'h42, 8, 1'b1, 1'b1, 1'b1, BITC);
        send_frame(8'h33, 8, 1'b1, 1'b0, 1'b1, BITC);
        take("R9 R10 address wakes", 8'h42, 1'b0, 1'b0, 1'b0, 1'b1);
        take("R9 data after wake", 8'h33, 1'b0, 1'b0, 1'b0, 1'b0);
        cfg_mdrop = 1'b0;

        // R11: watchdog
        wd_limit = 12'd25;
        send_frame(8'h5A, 8, 1'b0, 1'b0, 1'b1, BITC);
        repeat (100) @(negedge clk);
        check("R11 timeout pulse", n_wd, 1);
        repeat (300) @(negedge clk);
        check("R11 single pulse", n_wd, 1);
        take("R11 entry kept", 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0);
        wd_limit = '0;

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

endmodule